// File: doc/BRIEF.md
# Page-Group Access Rights Checker

This block decides whether one memory access may proceed under a page-group protection scheme. Each translated page belongs to a page group, named by a group identifier that arrives with the translation hit. The current protection domain holds a small set of group slots. Each slot has a valid flag, a group identifier and a write-disable flag. A page is reachable when its group identifier equals the identifier of a valid slot. Group zero is global and is reachable from every domain.

For a reachable page, the block combines the page's rights field, the current privilege level and the access kind. It answers allow or deny and gives a fault cause. A write-disable flag on a matching slot blocks every write to that group, whatever the rights field grants. The decision is combinational from the inputs and the slot state.

Software loads a slot, clears a slot, or purges all slots in one cycle. On a domain switch it purges the old domain's slots and then loads the new domain's slots. Slot updates are visible from the cycle after the clock edge that takes them.

Top module: `pgchk_top`

## Requirements
- R1: After reset every slot is invalid. A nonzero group then gets fault 1 (no group), and group 0 still reaches its rights check.
- R2: A nonzero group identifier is reachable when it equals the identifier of any valid slot, and gets fault 1 otherwise.
- R3: Group identifier 0 is reachable whatever the slot contents, and no slot's write-disable flag applies to it.
- R4: A cleared or never-loaded slot never makes a group reachable.
- R5: Rights field bits [6:5] are the write limit, bits [4:3] the read limit, bit 2 execute-permit, bit 1 write-permit and bit 0 read-permit. A read (access kind 0) is allowed only when bit 0 is set and the privilege level is numerically no greater than the read limit, where level 0 is the most privileged. Otherwise the fault is 2 (rights).
- R6: A write (access kind 1) is allowed only when bit 1 is set and the level is no greater than the write limit. Otherwise the fault is 2.
- R7: An execute (access kind 2) needs bit 2 set and a level no greater than the read limit. Access kind 3 is always refused with fault 2.
- R8: A write to a group whose matching valid slot has write-disable set is refused with fault 3, even when the rights allow it. Reads and executes to that group are unaffected.
- R9: Fault priority is no group (1), then write-disable (3), then rights (2). Fault 0 means allowed, and allow is 1 exactly when the fault is 0.
- R10: A purge invalidates all slots in one cycle. A load in the same cycle is dropped.
- R11: A slot load takes effect after the next rising clock edge. Until that edge the decision still follows the old slot state.
- R12: A clear invalidates only the selected slot. When a clear and a load target the same slot in one cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_gid | input | GID_W | Group identifier of the page being accessed |
| acc_rights | input | 7 | Rights field of the page |
| acc_pl | input | 2 | Current privilege level (0 is most privileged) |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| slot_wr_en | input | 1 | Load the selected slot |
| slot_wr_idx | input | IDX_W | Slot to load |
| slot_wr_gid | input | GID_W | Group identifier to load |
| slot_wr_wd | input | 1 | Write-disable flag to load |
| slot_clr_en | input | 1 | Invalidate one slot |
| slot_clr_idx | input | IDX_W | Slot to invalidate |
| slot_purge | input | 1 | Invalidate all slots |
| allow | output | 1 | Access permitted |
| fault | output | 2 | 0 none, 1 no group, 2 rights, 3 write-disable |

## Verification
The allow and fault outputs are due in the same cycle as the access inputs that cause them. The bench therefore drives an access on the falling edge and compares the outputs one nanosecond later, with no clock edge in between. Slot loads, clears and purges are due only after the following rising edge. For these, the bench checks the decision once before that edge, to confirm the old state still holds, and once after it, to confirm the new state.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

    localparam int PL_W = 2;

    typedef struct packed {
        logic [PL_W-1:0] wr_lim;
        logic [PL_W-1:0] rd_lim;
        logic            x_ok;
        logic            w_ok;
        logic            r_ok;
    } rights_t;

    localparam int RIGHTS_W = $bits(rights_t);

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2,
        KIND_RSVD  = 2'd3
    } kind_t;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_NO_GROUP = 2'd1,
        FLT_RIGHTS   = 2'd2,
        FLT_WR_DIS   = 2'd3
    } fault_t;

    // Level 0 is the most privileged: a smaller number passes a larger limit.
    function automatic logic level_ok(input logic [PL_W-1:0] cur,
                                      input logic [PL_W-1:0] lim);
        return cur <= lim;
    endfunction

    function automatic logic rights_grant(input rights_t rt,
                                          input kind_t kd,
                                          input logic [PL_W-1:0] cur);
        logic ok;
        case (kd)
            KIND_READ:  ok = rt.r_ok && level_ok(cur, rt.rd_lim);
            KIND_WRITE: ok = rt.w_ok && level_ok(cur, rt.wr_lim);
            KIND_EXEC:  ok = rt.x_ok && level_ok(cur, rt.rd_lim);
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pgchk_slots.sv
module pgchk_slots #(
    parameter int NUM_SLOTS = 4,
    parameter int GID_W     = 16,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [IDX_W-1:0]                 wr_idx,
    input  logic [GID_W-1:0]                 wr_gid,
    input  logic                             wr_wd,
    input  logic                             clr_en,
    input  logic [IDX_W-1:0]                 clr_idx,
    input  logic                             purge,
    output logic [NUM_SLOTS-1:0]             slot_vld,
    output logic [NUM_SLOTS-1:0]             slot_wd,
    output logic [NUM_SLOTS-1:0][GID_W-1:0]  slot_gid
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_vld[i] <= 1'b0;
                slot_wd[i]  <= 1'b0;
                slot_gid[i] <= '0;
            end else if (purge) begin
                slot_vld[i] <= 1'b0;
            end else if (clr_en && (clr_idx == IDX_W'(i))) begin
                slot_vld[i] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                slot_vld[i] <= 1'b1;
                slot_wd[i]  <= wr_wd;
                slot_gid[i] <= wr_gid;
            end
        end
    end

    AST_PURGE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        purge |=> (slot_vld == '0)); // R10

    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !purge && !(clr_en && clr_idx == wr_idx))
        |=> (slot_vld[$past(wr_idx)] && slot_gid[$past(wr_idx)] == $past(wr_gid)
             && slot_wd[$past(wr_idx)] == $past(wr_wd))); // R11

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !purge) |=> !slot_vld[$past(clr_idx)]); // R12

endmodule

// File: rtl/pgchk_match.sv
module pgchk_match #(
    parameter int NUM_SLOTS = 4,
    parameter int GID_W     = 16
) (
    input  logic [GID_W-1:0]                 acc_gid,
    input  logic [NUM_SLOTS-1:0]             slot_vld,
    input  logic [NUM_SLOTS-1:0]             slot_wd,
    input  logic [NUM_SLOTS-1:0][GID_W-1:0]  slot_gid,
    output logic                             gid_zero,
    output logic                             grp_hit,
    output logic                             wd_hit
);

    logic [NUM_SLOTS-1:0] hit;

    assign gid_zero = (acc_gid == '0);

    // The global group bypasses the slots, so no slot can hit on it.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
        assign hit[i] = slot_vld[i] && !gid_zero && (slot_gid[i] == acc_gid);
    end

    assign grp_hit = |hit;
    assign wd_hit  = |(hit & slot_wd);

endmodule

// File: rtl/pgchk_decide.sv
module pgchk_decide
    import pgchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gid_zero,
    input  logic              grp_hit,
    input  logic              wd_hit,
    input  rights_t           rights,
    input  logic [PL_W-1:0]   pl,
    input  kind_t             kind,
    output logic              allow,
    output fault_t            fault
);

    logic reachable;
    logic granted;
    logic wr_blocked;

    assign reachable  = gid_zero || grp_hit;
    assign granted    = rights_grant(rights, kind, pl);
    assign wr_blocked = (kind == KIND_WRITE) && wd_hit;

    always_comb begin
        if (!reachable)      fault = FLT_NO_GROUP;
        else if (wr_blocked) fault = FLT_WR_DIS;
        else if (!granted)   fault = FLT_RIGHTS;
        else                 fault = FLT_NONE;
    end

    assign allow = reachable && granted && !wr_blocked;

    AST_ALLOW_MEANS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        allow == (fault == FLT_NONE)); // R9

    AST_NO_GROUP_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!gid_zero && !grp_hit) |-> (fault == FLT_NO_GROUP && !allow)); // R9

    AST_WD_STOPS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (kind == KIND_WRITE && wd_hit) |-> !allow); // R8

    AST_RSVD_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (kind == KIND_RSVD) |-> !allow); // R7

endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
    import pgchk_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int GID_W     = 16,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GID_W-1:0]     acc_gid,
    input  logic [6:0]           acc_rights,
    input  logic [1:0]           acc_pl,
    input  logic [1:0]           acc_kind,
    input  logic                 slot_wr_en,
    input  logic [IDX_W-1:0]     slot_wr_idx,
    input  logic [GID_W-1:0]     slot_wr_gid,
    input  logic                 slot_wr_wd,
    input  logic                 slot_clr_en,
    input  logic [IDX_W-1:0]     slot_clr_idx,
    input  logic                 slot_purge,
    output logic                 allow,
    output logic [1:0]           fault
);

    logic [NUM_SLOTS-1:0]            vld;
    logic [NUM_SLOTS-1:0]            wd;
    logic [NUM_SLOTS-1:0][GID_W-1:0] gid;
    logic                            gid_zero;
    logic                            grp_hit;
    logic                            wd_hit;
    fault_t                          fault_e;

    pgchk_slots #(.NUM_SLOTS(NUM_SLOTS), .GID_W(GID_W)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (slot_wr_en),
        .wr_idx   (slot_wr_idx),
        .wr_gid   (slot_wr_gid),
        .wr_wd    (slot_wr_wd),
        .clr_en   (slot_clr_en),
        .clr_idx  (slot_clr_idx),
        .purge    (slot_purge),
        .slot_vld (vld),
        .slot_wd  (wd),
        .slot_gid (gid)
    );

    pgchk_match #(.NUM_SLOTS(NUM_SLOTS), .GID_W(GID_W)) u_match (
        .acc_gid  (acc_gid),
        .slot_vld (vld),
        .slot_wd  (wd),
        .slot_gid (gid),
        .gid_zero (gid_zero),
        .grp_hit  (grp_hit),
        .wd_hit   (wd_hit)
    );

    pgchk_decide u_decide (
        .clk      (clk),
        .rst      (rst),
        .gid_zero (gid_zero),
        .grp_hit  (grp_hit),
        .wd_hit   (wd_hit),
        .rights   (rights_t'(acc_rights)),
        .pl       (acc_pl),
        .kind     (kind_t'(acc_kind)),
        .allow    (allow),
        .fault    (fault_e)
    );

    assign fault = fault_e;

    AST_GLOBAL_REACHABLE: assert property (@(posedge clk) disable iff (rst)
        (acc_gid == '0) |-> (fault != FLT_NO_GROUP && fault != FLT_WR_DIS)); // R3

    AST_PURGE_THEN_MISS: assert property (@(posedge clk) disable iff (rst)
        $past(slot_purge) && !$past(rst) && (acc_gid != '0) && !$past(slot_wr_en)
        |-> (fault == FLT_NO_GROUP)); // R10

endmodule

// File: tb/test_pgchk_top.sv
`timescale 1ns/1ps
module test_pgchk_top;

    localparam int GID_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [GID_W-1:0] acc_gid = '0;
    logic [6:0]       acc_rights = '0;
    logic [1:0]       acc_pl = '0;
    logic [1:0]       acc_kind = '0;
    logic             slot_wr_en = 1'b0;
    logic [1:0]       slot_wr_idx = '0;
    logic [GID_W-1:0] slot_wr_gid = '0;
    logic             slot_wr_wd = 1'b0;
    logic             slot_clr_en = 1'b0;
    logic [1:0]       slot_clr_idx = '0;
    logic             slot_purge = 1'b0;
    logic             allow;
    logic [1:0]       fault;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pgchk_top #(.NUM_SLOTS(4), .GID_W(GID_W)) i_pgchk_top (
        .clk(clk), .rst(rst),
        .acc_gid(acc_gid), .acc_rights(acc_rights), .acc_pl(acc_pl), .acc_kind(acc_kind),
        .slot_wr_en(slot_wr_en), .slot_wr_idx(slot_wr_idx), .slot_wr_gid(slot_wr_gid),
        .slot_wr_wd(slot_wr_wd), .slot_clr_en(slot_clr_en), .slot_clr_idx(slot_clr_idx),
        .slot_purge(slot_purge), .allow(allow), .fault(fault)
    );

    // rights = {wr_lim[1:0], rd_lim[1:0], x, w, r}
    function automatic logic [6:0] rt(input logic [1:0] wl, input logic [1:0] rl,
                                      input logic [2:0] xwr);
        return {wl, rl, xwr};
    endfunction

    // vector: gid(16) rights(7) pl(2) kind(2) exp_fault(2) req(4)
    typedef struct packed {
        logic [15:0] gid;
        logic [6:0]  rights;
        logic [1:0]  pl;
        logic [1:0]  kind;
        logic [1:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    // Slots loaded: 0x0011 wd=0, 0x0022 wd=1, 0x0033 wd=0, slot 3 empty.
    localparam vec_t VECS [NV] = '{
        '{16'h0011, {2'd3,2'd3,3'b011}, 2'd2, 2'd0, 2'd0, 4'd5}, // R5 read ok
        '{16'h0011, {2'd3,2'd3,3'b011}, 2'd3, 2'd1, 2'd0, 4'd6}, // R6 write ok
        '{16'h0011, {2'd1,2'd3,3'b011}, 2'd2, 2'd1, 2'd2, 4'd6}, // R6 level too low
        '{16'h0011, {2'd3,2'd1,3'b011}, 2'd2, 2'd0, 2'd2, 4'd5}, // R5 level too low
        '{16'h0011, {2'd3,2'd3,3'b010}, 2'd0, 2'd0, 2'd2, 4'd5}, // R5 no read bit
        '{16'h0022, {2'd3,2'd3,3'b011}, 2'd0, 2'd1, 2'd3, 4'd8}, // R8 wd blocks
        '{16'h0022, {2'd3,2'd3,3'b011}, 2'd0, 2'd0, 2'd0, 4'd8}, // R8 read fine
        '{16'h0022, {2'd0,2'd3,3'b001}, 2'd2, 2'd1, 2'd3, 4'd9}, // R9 wd over rights
        '{16'h0044, {2'd3,2'd3,3'b111}, 2'd0, 2'd0, 2'd1, 4'd2}, // R2 no slot
        '{16'h0000, {2'd3,2'd3,3'b111}, 2'd3, 2'd1, 2'd0, 4'd3}, // R3 global
        '{16'h0000, {2'd3,2'd3,3'b000}, 2'd0, 2'd0, 2'd2, 4'd3}, // R3 still rights
        '{16'h0033, {2'd0,2'd2,3'b100}, 2'd2, 2'd2, 2'd0, 4'd7}, // R7 exec ok
        '{16'h0033, {2'd3,2'd1,3'b100}, 2'd2, 2'd2, 2'd2, 4'd7}, // R7 exec level
        '{16'h0033, {2'd3,2'd3,3'b111}, 2'd0, 2'd3, 2'd2, 4'd7}, // R7 reserved kind
        '{16'h0033, {2'd3,2'd3,3'b011}, 2'd0, 2'd2, 2'd2, 4'd7}, // R7 no exec bit
        '{16'h0044, {2'd0,2'd0,3'b000}, 2'd3, 2'd1, 2'd1, 4'd9}  // R9 no group first
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic chk(input logic [1:0] exp, input string req);
        checks++;
        if (fault !== exp || allow !== (exp == 2'd0)) begin
            errors++;
            $display("FAIL %s: fault=%0d allow=%0b expected fault=%0d allow=%0b",
                     req, fault, allow, exp, (exp == 2'd0));
        end
    endtask

    // drive an access on the falling edge; compare 1 ns later
    task automatic access(input logic [15:0] g, input logic [6:0] r, input logic [1:0] p,
                          input logic [1:0] k, input logic [1:0] exp, input string req);
        @(negedge clk);
        acc_gid = g; acc_rights = r; acc_pl = p; acc_kind = k;
        #1;
        chk(exp, req);
    endtask

    task automatic load(input logic [1:0] idx, input logic [15:0] g, input logic wdis);
        @(negedge clk);
        slot_wr_en = 1'b1; slot_wr_idx = idx; slot_wr_gid = g; slot_wr_wd = wdis;
        @(negedge clk);
        slot_wr_en = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        access(16'h0011, rt(3,3,3'b111), 2'd0, 2'd0, 2'd1, "R1 empty after reset");
        access(16'h0000, rt(3,3,3'b111), 2'd0, 2'd1, 2'd0, "R1 global after reset");

        // R11 load timing: old state until the edge, new state after
        @(negedge clk);
        acc_gid = 16'h0011; acc_rights = rt(3,3,3'b011); acc_pl = 2'd0; acc_kind = 2'd0;
        slot_wr_en = 1'b1; slot_wr_idx = 2'd0; slot_wr_gid = 16'h0011; slot_wr_wd = 1'b0;
        #1; chk(2'd1, "R11 before edge");
        @(negedge clk);
        slot_wr_en = 1'b0;
        #1; chk(2'd0, "R11 after edge");

        load(2'd1, 16'h0022, 1'b1);
        load(2'd2, 16'h0033, 1'b0);

        // table walk (R2 R3 R5 R6 R7 R8 R9)
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].gid, VECS[i].rights, VECS[i].pl, VECS[i].kind, VECS[i].exp,
                   $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R4 empty slot 3 holds gid 0 and is invalid: group 0x0000 is global anyway, so probe 0x0055
        access(16'h0055, rt(3,3,3'b111), 2'd0, 2'd0, 2'd1, "R4 never-loaded slot");

        // R12 clear only slot 2
        @(negedge clk);
        slot_clr_en = 1'b1; slot_clr_idx = 2'd2;
        @(negedge clk);
        slot_clr_en = 1'b0;
        access(16'h0033, rt(3,3,3'b111), 2'd0, 2'd0, 2'd1, "R12 cleared slot misses");
        access(16'h0011, rt(3,3,3'b111), 2'd0, 2'd0, 2'd0, "R12 other slot kept");
        access(16'h0033, rt(3,3,3'b111), 2'd0, 2'd0, 2'd1, "R4 cleared slot no match");

        // R12 clear beats load on the same slot
        @(negedge clk);
        slot_clr_en = 1'b1; slot_clr_idx = 2'd3;
        slot_wr_en = 1'b1; slot_wr_idx = 2'd3; slot_wr_gid = 16'h0066; slot_wr_wd = 1'b0;
        @(negedge clk);
        slot_clr_en = 1'b0; slot_wr_en = 1'b0;
        access(16'h0066, rt(3,3,3'b111), 2'd0, 2'd0, 2'd1, "R12 clear wins over load");

        // R10 purge with a same-cycle load
        @(negedge clk);
        slot_purge = 1'b1;
        slot_wr_en = 1'b1; slot_wr_idx = 2'd3; slot_wr_gid = 16'h0077; slot_wr_wd = 1'b0;
        acc_gid = 16'h0011; acc_rights = rt(3,3,3'b111); acc_pl = 2'd0; acc_kind = 2'd0;
        #1; chk(2'd0, "R10 still loaded before edge");
        @(negedge clk);
        slot_purge = 1'b0; slot_wr_en = 1'b0;
        access(16'h0011, rt(3,3,3'b111), 2'd0, 2'd0, 2'd1, "R10 slot0 purged");
        access(16'h0022, rt(3,3,3'b111), 2'd0, 2'd1, 2'd1, "R10 slot1 purged");
        access(16'h0077, rt(3,3,3'b111), 2'd0, 2'd0, 2'd1, "R10 load dropped");

        // reload for new domain; write-disable now off for 0x0022
        load(2'd0, 16'h0022, 1'b0);
        access(16'h0022, rt(3,3,3'b111), 2'd0, 2'd1, 2'd0, "R8 reload without wd");
        access(16'h0000, rt(3,3,3'b111), 2'd0, 2'd1, 2'd0, "R3 global write");

        finish_run();
    end

endmodule